// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip. A serial test clock, a mode-select line and a data input drive the standard 16-state controller. That controller walks a 6-bit instruction register and a set of data registers through capture, shift and update phases. The data registers are a single bypass bit, a 32-bit identification word, a boundary chain of parameterised length and a 2-bit self-test status word. Serial data leaves on a test data output whose enable is raised only while a register is being shifted.

The active instruction drives three chip-level controls. One turns every chip output and bidirectional pin to high impedance and also switches off the pull resistors. One hands the output pins over to the boundary chain's update latches. One selects which register the next data scan captures. A separate self-test engine reports done and pass flags, which the status register samples. The pad cells and the self-test engine sit outside this block.

Top module: `scan_port_ctrl`

## Requirements
- R1: The controller follows the standard 16-state sequence on each rising edge of `tck`. Five consecutive rising edges with `tms` = 1 reach Test-Logic-Reset from any state.
- R2: While `trst_n` is low, and on any edge in Test-Logic-Reset, the active instruction becomes IDCODE (6'b000100). A data scan then returns the 32-bit word {version[31:28], part[27:12], maker[11:1], 1'b1}, built from parameters.
- R3: In Capture-IR the instruction shifter loads 6'b000001. An instruction becomes active only on the edge that leaves Update-IR.
- R4: BYPASS (6'b111111) selects a 1-bit register that captures 0. Data passes through it with one bit of delay.
- R5: Any opcode outside {000000, 000001, 000100, 000101, 000110, 111111} acts as BYPASS. It raises neither `hiz_all` nor `bnd_drive_en`, and it leaves `pin_drive` unchanged.
- R6: While HIGHZ (6'b000101) is active, `hiz_all` = 1 and `pull_en` = 0. Under every other instruction, `hiz_all` = 0 and `pull_en` = 1.
- R7: Under the self-test opcode (6'b000110), Capture-DR loads {pass & done, done}. Bit 0 = 1 means the test is complete. Bit 1 = 1 means it passed, and bit 1 reads 0 while bit 0 is 0.
- R8: Under SAMPLE/PRELOAD (000001) and EXTEST (000000), Capture-DR loads `pin_in` into a BSR_LEN-bit chain, and Update-DR copies the chain into `pin_drive`. No other instruction changes `pin_drive`.
- R9: `bnd_drive_en` is 1 exactly while EXTEST is active.
- R10: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is 1 only during Shift-IR and Shift-DR.
- R11: In Shift-IR and Shift-DR, `tdi` enters the most significant bit and the least significant bit leaves on `tdo` first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Output enable for `tdo` |
| pin_in | input | BSR_LEN | Pin values sampled by the boundary chain |
| pin_drive | output | BSR_LEN | Boundary update latches |
| bnd_drive_en | output | 1 | Latches drive the output pins (EXTEST) |
| hiz_all | output | 1 | Global output disable |
| pull_en | output | 1 | Pull resistor enable |
| bist_done | input | 1 | Self-test complete flag |
| bist_pass | input | 1 | Self-test result flag |

## Verification
The controller state moves on each rising edge, and a capture takes place on the rising edge that leaves a Capture state. The captured value's least significant bit therefore appears on `tdo` at the following falling edge. Instruction controls such as `hiz_all` and `bnd_drive_en`, and the `pin_drive` latches, change on the rising edge that leaves Update-IR or Update-DR, so they are due one edge after the Update state is entered. The bench drives `tms` and `tdi` 1 ns after each falling edge and reads `tdo`, `tdo_oe` and the controls at that same point, before the next rising edge. It also checks that `hiz_all` is still low at Exit1-IR and at Update-IR, one edge before it is due.

// File: rtl/scan_pkg.sv
package scan_pkg;

  localparam int IR_W = 6;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BND, SEL_BIST} dr_sel_e;

  localparam logic [IR_W-1:0] OP_EXTEST = 6'b000000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 6'b000001;
  localparam logic [IR_W-1:0] OP_IDCODE = 6'b000100;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 6'b000101;
  localparam logic [IR_W-1:0] OP_BIST   = 6'b000110;
  localparam logic [IR_W-1:0] OP_BYPASS = 6'b111111;
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 6'b000001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_RESET:  return m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: return m ? ST_SEL_DR : ST_IDLE;
      default:   return ST_RESET;
    endcase
  endfunction

  function automatic dr_sel_e decode_dr(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLE: return SEL_BND;
      OP_IDCODE:            return SEL_ID;
      OP_BIST:              return SEL_BIST;
      default:              return SEL_BYP;
    endcase
  endfunction

  function automatic logic is_known_op(input logic [IR_W-1:0] op);
    return (op == OP_EXTEST) || (op == OP_SAMPLE) || (op == OP_IDCODE) ||
           (op == OP_HIGHZ) || (op == OP_BIST) || (op == OP_BYPASS);
  endfunction

  function automatic logic [ID_W-1:0] id_word(input logic [3:0] ver,
                                              input logic [15:0] part,
                                              input logic [10:0] maker);
    return {ver, part, maker, 1'b1};
  endfunction

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= tap_next(state, tms);
  end
endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_cur,
  output logic            ir_lsb
);
  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh  <= '0;
      ir_cur <= OP_IDCODE;
    end else begin
      case (state)
        ST_RESET:  ir_cur <= OP_IDCODE;
        ST_CAP_IR: ir_sh  <= IR_CAPTURE_PAT;
        ST_SH_IR:  ir_sh  <= {tdi, ir_sh[IR_W-1:1]};
        ST_UPD_IR: ir_cur <= ir_sh;
        default: ;
      endcase
    end
  end

  assign ir_lsb = ir_sh[0];
endmodule

// File: rtl/scan_dr.sv
module scan_dr
  import scan_pkg::*;
#(
  parameter int              BSR_LEN = 8,
  parameter logic [ID_W-1:0] ID_VAL  = 32'h1
) (
  input  logic               tck,
  input  logic               trst_n,
  input  tap_state_e         state,
  input  dr_sel_e            dr_sel,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_in,
  input  logic               bist_done,
  input  logic               bist_pass,
  output logic               dr_lsb,
  output logic [BSR_LEN-1:0] pin_drive,
  output logic [1:0]         bist_cap
);
  logic            byp_q;
  logic [ID_W-1:0] id_q;
  logic [1:0]      bist_q;
  logic [BSR_LEN-1:0] bnd_q;
  logic [BSR_LEN:0]   bnd_in;

  wire cap_ev = (state == ST_CAP_DR);
  wire sh_ev  = (state == ST_SH_DR);
  wire upd_ev = (state == ST_UPD_DR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q  <= 1'b0;
      id_q   <= ID_VAL;
      bist_q <= 2'b00;
    end else if (cap_ev) begin
      if (dr_sel == SEL_BYP)  byp_q  <= 1'b0;
      if (dr_sel == SEL_ID)   id_q   <= ID_VAL;
      if (dr_sel == SEL_BIST) bist_q <= {bist_pass & bist_done, bist_done};
    end else if (sh_ev) begin
      if (dr_sel == SEL_BYP)  byp_q  <= tdi;
      if (dr_sel == SEL_ID)   id_q   <= {tdi, id_q[ID_W-1:1]};
      if (dr_sel == SEL_BIST) bist_q <= {tdi, bist_q[1]};
    end
  end

  // Boundary chain: one capture/shift/update cell per pin
  assign bnd_in[BSR_LEN] = tdi;
  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    assign bnd_in[i] = bnd_q[i];
    always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
        bnd_q[i]     <= 1'b0;
        pin_drive[i] <= 1'b0;
      end else if (dr_sel == SEL_BND) begin
        if (cap_ev)      bnd_q[i]     <= pin_in[i];
        else if (sh_ev)  bnd_q[i]     <= bnd_in[i+1];
        else if (upd_ev) pin_drive[i] <= bnd_q[i];
      end
    end
  end

  always_comb begin
    case (dr_sel)
      SEL_ID:   dr_lsb = id_q[0];
      SEL_BND:  dr_lsb = bnd_in[0];
      SEL_BIST: dr_lsb = bist_q[0];
      default:  dr_lsb = byp_q;
    endcase
  end

  assign bist_cap = bist_q;
endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_pkg::*;
#(
  parameter int          BSR_LEN  = 8,
  parameter logic [3:0]  ID_VER   = 4'h3,
  parameter logic [15:0] ID_PART  = 16'hA5C3,
  parameter logic [10:0] ID_MAKER = 11'h2B5
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic [BSR_LEN-1:0] pin_drive,
  output logic               bnd_drive_en,
  output logic               hiz_all,
  output logic               pull_en,
  input  logic               bist_done,
  input  logic               bist_pass
);
  localparam logic [ID_W-1:0] ID_VAL = id_word(ID_VER, ID_PART, ID_MAKER);

  tap_state_e      tap_state;
  logic [IR_W-1:0] ir_cur;
  logic            ir_lsb;
  logic            dr_lsb;
  logic [1:0]      bist_cap;
  dr_sel_e         dr_sel;

  scan_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_state)
  );

  scan_ir u_ir (
    .tck(tck), .trst_n(trst_n), .state(tap_state), .tdi(tdi),
    .ir_cur(ir_cur), .ir_lsb(ir_lsb)
  );

  assign dr_sel = decode_dr(ir_cur);

  scan_dr #(.BSR_LEN(BSR_LEN), .ID_VAL(ID_VAL)) u_dr (
    .tck(tck), .trst_n(trst_n), .state(tap_state), .dr_sel(dr_sel),
    .tdi(tdi), .pin_in(pin_in), .bist_done(bist_done), .bist_pass(bist_pass),
    .dr_lsb(dr_lsb), .pin_drive(pin_drive), .bist_cap(bist_cap)
  );

  wire in_sh_ir = (tap_state == ST_SH_IR);
  wire in_sh_dr = (tap_state == ST_SH_DR);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= in_sh_ir ? ir_lsb : dr_lsb;
      tdo_oe <= in_sh_ir | in_sh_dr;
    end
  end

  assign hiz_all      = (ir_cur == OP_HIGHZ);
  assign pull_en      = ~hiz_all;
  assign bnd_drive_en = (ir_cur == OP_EXTEST);
endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_pkg::*;
#(
  parameter int BSR_LEN = 8
) (
  input logic               tck,
  input logic               trst_n,
  input logic               tms,
  input tap_state_e         state,
  input logic [IR_W-1:0]    ir_cur,
  input dr_sel_e            dr_sel,
  input logic [1:0]         bist_cap,
  input logic               hiz_all,
  input logic               bnd_drive_en,
  input logic               tdo_oe,
  input logic [BSR_LEN-1:0] pin_drive
);
  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)             ones_cnt <= 3'd0;
    else if (!tms)           ones_cnt <= 3'd0;
    else if (ones_cnt < 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt == 3'd5) |-> (state == ST_RESET)); // R1

  AST_IR_CHANGE_POINT: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(ir_cur) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_RESET)); // R3

  AST_HIZ_AT_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(hiz_all) |-> ($past(state) == ST_UPD_IR)); // R6

  AST_RESERVED_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
    !is_known_op(ir_cur) |-> (!hiz_all && !bnd_drive_en && dr_sel == SEL_BYP)); // R5

  AST_BIST_PASS_VALID: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_DR && dr_sel == SEL_BIST) |=> (!bist_cap[1] || bist_cap[0])); // R7

  AST_PIN_UPDATE_POINT: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(pin_drive) |-> ($past(state) == ST_UPD_DR && $past(dr_sel) == SEL_BND)); // R8

  AST_OE_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == ST_SH_DR || state == ST_SH_IR)); // R10
endmodule

bind scan_port_ctrl scan_port_chk #(.BSR_LEN(BSR_LEN)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_state), .ir_cur(ir_cur),
  .dr_sel(dr_sel), .bist_cap(bist_cap), .hiz_all(hiz_all),
  .bnd_drive_en(bnd_drive_en), .tdo_oe(tdo_oe), .pin_drive(pin_drive)
);

// File: tb/scan_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module scan_port_ctrl_tb_top;
  localparam int N = 8;
  localparam logic [3:0]  VER   = 4'h3;
  localparam logic [15:0] PART  = 16'hA5C3;
  localparam logic [10:0] MAKER = 11'h2B5;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe, bnd_drive_en, hiz_all, pull_en;
  logic bist_done = 1'b0, bist_pass = 1'b0;
  logic [N-1:0] pin_in = '0, pin_drive;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic oe_seen;

  always #2.5 tck = ~tck;

  scan_port_ctrl #(.BSR_LEN(N), .ID_VER(VER), .ID_PART(PART), .ID_MAKER(MAKER)) dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .pin_drive(pin_drive), .bnd_drive_en(bnd_drive_en),
    .hiz_all(hiz_all), .pull_en(pull_en), .bist_done(bist_done), .bist_pass(bist_pass)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one TMS value, advance one rising edge, settle after the falling edge
  task automatic step(input logic m);
    tms = m;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  // From a Shift state: n bits in, LSB first; last bit leaves with TMS=1 (Exit1)
  task automatic shift(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    oe_seen = 1'b1;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      oe_seen &= tdo_oe;
      tdi = din[i];
      step(i == n - 1);
    end
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    step(1); step(0); step(0);
    shift(n, din, dout);
    step(1); step(0);
  endtask

  task automatic load_ir(input logic [5:0] op, output logic [63:0] cap);
    step(1); step(1); step(0); step(0);
    shift(6, {58'd0, op}, cap);
    step(1); step(0);
  endtask

  task automatic do_reset();
    trst_n = 1'b0; tms = 1'b1;
    repeat (3) @(negedge tck);
    #1 trst_n = 1'b1;
    step(0);
  endtask

  task automatic t_reset_id();
    logic [63:0] o;
    do_reset();
    check("R6 reset hiz", hiz_all, 0);
    check("R6 reset pull", pull_en, 1);
    check("R9 reset drive_en", bnd_drive_en, 0);
    check("R10 idle oe", tdo_oe, 0);
    scan_dr(32, 64'h0, o);
    check("R2 id word", o[31:0], {VER, PART, MAKER, 1'b1});
    check("R10 oe in shift", oe_seen, 1);
    check("R10 oe after shift", tdo_oe, 0);
  endtask

  task automatic t_bypass();
    logic [63:0] o;
    load_ir(6'b111111, o);
    check("R3 ir capture", o[5:0], 6'b000001);
    scan_dr(8, 64'hB2, o);
    check("R4 bypass delay", o[7:0], {8'hB2 << 1});
    check("R11 bypass lsb captured 0", o[0], 0);
  endtask

  task automatic t_highz();
    logic [63:0] o;
    step(1); step(1); step(0); step(0);
    shift(6, 64'b000101, o);
    check("R3 no effect at exit1", hiz_all, 0);
    step(1);
    check("R3 no effect in update", hiz_all, 0);
    step(0);
    check("R6 hiz on", hiz_all, 1);
    check("R6 pull off", pull_en, 0);
    step(1); step(0); step(0);
    step(1); step(1); step(1); step(1); step(1);
    step(0);
    check("R1 five ones to reset", hiz_all, 0);
    check("R1 pull back", pull_en, 1);
    scan_dr(32, 64'h0, o);
    check("R2 reset re-selects id", o[31:0], {VER, PART, MAKER, 1'b1});
  endtask

  task automatic t_bist();
    logic [63:0] o;
    load_ir(6'b000110, o);
    bist_done = 0; bist_pass = 1;
    scan_dr(2, 64'h0, o);
    check("R7 running", o[1:0], 2'b00);
    bist_done = 1; bist_pass = 0;
    scan_dr(2, 64'h0, o);
    check("R7 done fail", o[1:0], 2'b01);
    bist_pass = 1;
    scan_dr(2, 64'h0, o);
    check("R7 done pass", o[1:0], 2'b11);
  endtask

  task automatic t_boundary();
    logic [63:0] o;
    load_ir(6'b000001, o);
    check("R9 sample no drive", bnd_drive_en, 0);
    pin_in = 8'hC6;
    scan_dr(N, 64'h3A, o);
    check("R8 sample capture", o[7:0], 8'hC6);
    check("R8 sample update", pin_drive, 8'h3A);
    load_ir(6'b000000, o);
    check("R9 extest drive", bnd_drive_en, 1);
    pin_in = 8'h5F;
    scan_dr(N, 64'h81, o);
    check("R8 extest capture", o[7:0], 8'h5F);
    check("R8 extest update", pin_drive, 8'h81);
    load_ir(6'b000100, o);
    check("R9 idcode no drive", bnd_drive_en, 0);
    scan_dr(32, 64'hFFFF_FFFF, o);
    check("R8 idcode keeps latches", pin_drive, 8'h81);
  endtask

  task automatic t_reserved();
    logic [63:0] o;
    load_ir(6'b001010, o);
    check("R5 reserved no hiz", hiz_all, 0);
    check("R5 reserved no drive", bnd_drive_en, 0);
    scan_dr(8, 64'h6D, o);
    check("R5 reserved is bypass", o[7:0], {8'h6D << 1});
    check("R5 reserved keeps latches", pin_drive, 8'h81);
    check("R11 bit order", o[1], 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_id();
    t_bypass();
    t_highz();
    t_bist();
    t_boundary();
    t_reserved();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule